// File: doc/BRIEF.md
# Paged Multichannel Register Bank Selector

This block is the register-access front end of a device that keeps one shared register set and four per-channel register sets. It sits behind a plain parallel register bus with an address, write data, a write strobe, a read strobe and registered read data. A page register at the top address steers every other access. Depending on the page, an access goes to the shared set or to one channel's set. In broadcast mode a single write lands in all four channel sets at once, and reads still come from one chosen channel.

The page register holds four defined bits. Bit 2 enables channel mode. Bits [1:0] name the target channel. Bit 3 turns on broadcast, and it only matters while bit 2 is set. The register sets are plain byte storage with no side effects. The host can always reach the page register, whatever page is active.

Top module: `pgsel_bank`

## Requirements
- R1: While reset is asserted and right after it, rd_data is 0x00, the page register is 0x00, and every byte of all five register sets reads 0x00.
- R2: A read of address 0xFF returns the last value written to 0xFF in bits [3:0], and bits [7:4] read as zero.
- R3: With page bit 2 clear, a read or write at any address from 0x00 to 0xFE reaches the shared register set and leaves the channel sets unchanged.
- R4: With page bit 2 set and bit 3 clear, an access at 0x00 to 0xFE reaches only the channel set numbered by page bits [1:0] (0x04 is channel 0, 0x07 is channel 3).
- R5: Page bit 3 has no effect while bit 2 is clear, so a page of 0x08 steers accesses to the shared set.
- R6: With page bits 3 and 2 both set (0x0C to 0x0F), a write at 0x00 to 0xFE updates that address in all four channel sets on the same edge and leaves the shared set unchanged.
- R7: In broadcast mode a read returns the byte of the single channel named by page bits [1:0].
- R8: An access at 0xFF always reaches the page register, whatever page is selected, including channel and broadcast pages.
- R9: rd_data changes only on the clock edge that samples rd_en high, and it then shows the addressed byte as it stood before any write on that same edge. It holds its value in every other cycle.
- R10: A page write takes effect on the edge that samples it, so it steers only accesses sampled on later edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, sampled on the rising edge |
| rd_en | input | 1 | Read strobe, sampled on the rising edge |
| addr | input | 8 | Register address; 0xFF is the page register |
| wdata | input | 8 | Write data |
| rd_data | output | 8 | Registered read data, valid one clock after rd_en |

## Verification
The bench tries to catch writes that land in the wrong place. A page of 0x08 must not leak into channel mode. A broadcast write must not touch the shared set, and it must not reach only the targeted channel. A write to 0xFF while a channel page is active must not fall into a channel set instead of the page register. The bench also drives a read and a page write to 0xFF on the same edge. A design that used the new page too early, or that returned the post-write byte, would give the wrong read data there. Each of these cases is followed by reads through other pages, so the bench can see whether a set that should have stayed unchanged was changed.

// File: rtl/pgsel_pkg.sv
`timescale 1ns/1ps
package pgsel_pkg;
    localparam int ADDR_W    = 8;
    localparam int DATA_W    = 8;
    localparam int NUM_CH    = 4;
    localparam int CH_W      = $clog2(NUM_CH);
    localparam int NUM_SETS  = NUM_CH + 1;
    localparam int SEL_W     = $clog2(NUM_SETS);
    localparam int PAGE_W    = CH_W + 2;
    localparam int SET_DEPTH = (1 << ADDR_W) - 1;
    localparam logic [ADDR_W-1:0] PAGE_ADDR = '1;

    // page register layout: broadcast above channel enable above channel number
    typedef struct packed {
        logic            bcast;
        logic            ch_en;
        logic [CH_W-1:0] ch;
    } page_t;
endpackage

// File: rtl/pgsel_page_reg.sv
`timescale 1ns/1ps
module pgsel_page_reg
    import pgsel_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  we,
    input  page_t wpage,
    output page_t page
);
    typedef struct packed {
        page_t page;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (we) begin
            st_d.page = wpage;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign page = st_q.page;
endmodule

// File: rtl/pgsel_route.sv
`timescale 1ns/1ps
module pgsel_route
    import pgsel_pkg::*;
(
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   addr,
    input  page_t               page,
    output logic                page_we,
    output logic                rd_is_page,
    output logic [SEL_W-1:0]    rd_sel,
    output logic [NUM_SETS-1:0] set_we
);
    logic hit_page;
    logic data_wr;

    always_comb begin
        hit_page   = (addr == PAGE_ADDR);
        data_wr    = wr_en && !hit_page;
        page_we    = wr_en && hit_page;
        rd_is_page = hit_page;
        if (page.ch_en) begin
            rd_sel = SEL_W'(page.ch) + SEL_W'(1);
        end else begin
            rd_sel = '0;
        end
    end

    for (genvar g = 0; g < NUM_SETS; g++) begin : g_we
        if (g == 0) begin : g_shared
            assign set_we[g] = data_wr && !page.ch_en;
        end else begin : g_chan
            assign set_we[g] = data_wr && page.ch_en &&
                               (page.bcast || (page.ch == CH_W'(g - 1)));
        end
    end
endmodule

// File: rtl/pgsel_reg_set.sv
`timescale 1ns/1ps
module pgsel_reg_set #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8,
    parameter int DEPTH  = (1 << ADDR_W) - 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    localparam logic [ADDR_W-1:0] LAST = ADDR_W'(DEPTH - 1);

    logic [DATA_W-1:0] mem_d [DEPTH];
    logic [DATA_W-1:0] mem_q [DEPTH];

    always_comb begin
        mem_d = mem_q;
        if (we && (addr <= LAST)) begin
            mem_d[addr] = wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= '0;
            end
        end else begin
            mem_q <= mem_d;
        end
    end

    always_comb begin
        if (addr <= LAST) begin
            rdata = mem_q[addr];
        end else begin
            rdata = '0;
        end
    end
endmodule

// File: rtl/pgsel_bank.sv
`timescale 1ns/1ps
module pgsel_bank
    import pgsel_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rd_data
);
    typedef struct packed {
        logic [DATA_W-1:0] rd_data;
    } state_t;

    state_t st_d, st_q;

    page_t               page_q;
    logic                page_we;
    logic                rd_is_page;
    logic [SEL_W-1:0]    rd_sel;
    logic [NUM_SETS-1:0] set_we;
    logic [DATA_W-1:0]   set_rdata [NUM_SETS];
    logic [DATA_W-1:0]   sel_rdata;

    pgsel_page_reg u_page (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (page_we),
        .wpage (page_t'(wdata[PAGE_W-1:0])),
        .page  (page_q)
    );

    pgsel_route u_route (
        .wr_en      (wr_en),
        .addr       (addr),
        .page       (page_q),
        .page_we    (page_we),
        .rd_is_page (rd_is_page),
        .rd_sel     (rd_sel),
        .set_we     (set_we)
    );

    for (genvar s = 0; s < NUM_SETS; s++) begin : g_set
        pgsel_reg_set #(
            .ADDR_W (ADDR_W),
            .DATA_W (DATA_W),
            .DEPTH  (SET_DEPTH)
        ) u_set (
            .clk   (clk),
            .rst_n (rst_n),
            .we    (set_we[s]),
            .addr  (addr),
            .wdata (wdata),
            .rdata (set_rdata[s])
        );
    end

    always_comb begin
        sel_rdata = '0;
        for (int i = 0; i < NUM_SETS; i++) begin
            if (rd_sel == SEL_W'(i)) begin
                sel_rdata = set_rdata[i];
            end
        end
    end

    always_comb begin
        st_d = st_q;
        if (rd_en) begin
            st_d.rd_data = rd_is_page ? DATA_W'(page_q) : sel_rdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_data = st_q.rd_data;
endmodule

// File: rtl/pgsel_bank_chk.sv
`timescale 1ns/1ps
module pgsel_bank_chk
    import pgsel_pkg::*;
(
    input logic                clk,
    input logic                rst_n,
    input logic                wr_en,
    input logic                rd_en,
    input logic [ADDR_W-1:0]   addr,
    input logic [DATA_W-1:0]   wdata,
    input logic [DATA_W-1:0]   rd_data,
    input page_t               page_q,
    input logic [NUM_SETS-1:0] set_we
);
    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |-> (rd_data == '0 && page_q == '0));

    p_page_upper_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == PAGE_ADDR) |=> (rd_data[DATA_W-1:PAGE_W] == '0));

    p_shared_only_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr != PAGE_ADDR && !page_q.ch_en) |-> (set_we == NUM_SETS'(1)));

    p_write_targets_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr != PAGE_ADDR && page_q.ch_en && page_q.bcast)
            |-> (set_we == {{NUM_CH{1'b1}}, 1'b0}));

    p_page_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == PAGE_ADDR) |-> (set_we == '0));

    p_page_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == PAGE_ADDR) |=> (page_q == $past(wdata[PAGE_W-1:0])));

    p_rdata_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rd_data));

    p_page_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && addr == PAGE_ADDR) |=> $stable(page_q));

    p_idle_no_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |-> ($countones(set_we) == 0));
endmodule

bind pgsel_bank pgsel_bank_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .rd_en   (rd_en),
    .addr    (addr),
    .wdata   (wdata),
    .rd_data (rd_data),
    .page_q  (page_q),
    .set_we  (set_we)
);

// File: tb/pgsel_bank_bench.sv
`timescale 1ns/1ps
module pgsel_bank_bench;
    logic       clk   = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic [7:0] addr  = 8'h00;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rd_data;

    int checks   = 0;
    int failures = 0;

    logic [7:0] ref_mem [5][255];
    logic [3:0] ref_page;
    logic [7:0] ref_rd;

    always #10 clk = ~clk;

    pgsel_bank u_pgsel_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .rd_en   (rd_en),
        .addr    (addr),
        .wdata   (wdata),
        .rd_data (rd_data)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] model_read(input logic [7:0] a);
        if (a == 8'hFF) return {4'h0, ref_page};
        if (ref_page[2]) return ref_mem[1 + int'(ref_page[1:0])][a];
        return ref_mem[0][a];
    endfunction

    task automatic model_write(input logic [7:0] a, input logic [7:0] d);
        if (a == 8'hFF) begin
            ref_page = d[3:0];
        end else if (!ref_page[2]) begin
            ref_mem[0][a] = d;
        end else if (ref_page[3]) begin
            for (int c = 1; c < 5; c++) ref_mem[c][a] = d;
        end else begin
            ref_mem[1 + int'(ref_page[1:0])][a] = d;
        end
    endtask

    // one bus cycle; model updated at the edge, output sampled 2 ns later
    task automatic step(input bit w, input bit r, input logic [7:0] a,
                        input logic [7:0] d, input string req);
        wr_en = w; rd_en = r; addr = a; wdata = d;
        @(posedge clk);
        if (r) ref_rd = model_read(a);
        if (w) model_write(a, d);
        #2;
        wr_en = 1'b0; rd_en = 1'b0;
        check(req, rd_data, ref_rd);
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d, input string req);
        step(1'b1, 1'b0, a, d, req);
    endtask

    task automatic rd(input logic [7:0] a, input string req);
        step(1'b0, 1'b1, a, 8'h00, req);
    endtask

    initial begin
        for (int s = 0; s < 5; s++)
            for (int i = 0; i < 255; i++) ref_mem[s][i] = 8'h00;
        ref_page = 4'h0;
        ref_rd   = 8'h00;

        repeat (3) @(posedge clk);
        #2;
        check("R1 rd_data in reset", rd_data, 8'h00);
        rst_n = 1'b1;

        rd(8'hFF, "R1 page after reset");
        rd(8'h10, "R1 shared after reset");
        rd(8'hFE, "R1 top byte after reset");

        wr(8'h10, 8'h5A, "R3 write shared");
        rd(8'h10, "R3 read shared");

        wr(8'hFF, 8'h04, "R4 select ch0");
        wr(8'h10, 8'h11, "R4 write ch0");
        wr(8'hFF, 8'h07, "R4 select ch3");
        wr(8'h10, 8'h77, "R4 write ch3");
        rd(8'h10, "R4 read ch3");
        wr(8'hFF, 8'h04, "R4 reselect ch0");
        rd(8'h10, "R4 read ch0");
        wr(8'hFF, 8'h05, "R4 select ch1");
        rd(8'h10, "R4 ch1 untouched");
        wr(8'hFF, 8'h00, "R3 back to shared");
        rd(8'h10, "R3 shared untouched by channel writes");

        wr(8'hFF, 8'hF6, "R2 write page with upper bits");
        rd(8'hFF, "R2 page readback masked");

        wr(8'hFF, 8'h08, "R5 broadcast bit alone");
        wr(8'h20, 8'h3C, "R5 write under 0x08");
        rd(8'h20, "R5 lands in shared");
        wr(8'hFF, 8'h04, "R5 select ch0");
        rd(8'h20, "R5 ch0 untouched");

        wr(8'hFF, 8'h0D, "R6 broadcast page");
        wr(8'h30, 8'hC3, "R6 broadcast write");
        for (int c = 0; c < 4; c++) begin
            wr(8'hFF, 8'(8'h04 + c), "R6 select channel");
            rd(8'h30, "R6 every channel updated");
        end
        wr(8'hFF, 8'h00, "R6 shared page");
        rd(8'h30, "R6 shared untouched");

        wr(8'hFF, 8'h06, "R7 select ch2");
        wr(8'h40, 8'h66, "R7 write ch2");
        wr(8'hFF, 8'h05, "R7 select ch1");
        wr(8'h40, 8'h55, "R7 write ch1");
        wr(8'hFF, 8'h0E, "R7 broadcast target ch2");
        rd(8'h40, "R7 broadcast read ch2");
        wr(8'hFF, 8'h0D, "R7 broadcast target ch1");
        rd(8'h40, "R7 broadcast read ch1");

        wr(8'hFF, 8'h0F, "R8 page write in broadcast page");
        rd(8'hFF, "R8 page read in broadcast page");
        wr(8'hFF, 8'h07, "R8 page write in channel page");
        rd(8'hFF, "R8 page read in channel page");
        wr(8'hFF, 8'h00, "R8 leave channel page");
        rd(8'hFF, "R8 page reached from channel page");

        rd(8'h10, "R9 read before hold");
        step(1'b0, 1'b0, 8'h20, 8'h00, "R9 hold idle");
        wr(8'h10, 8'hA1, "R9 hold across write");
        rd(8'h10, "R9 read new value");
        step(1'b1, 1'b1, 8'h10, 8'hB2, "R9 same-edge read returns old");
        rd(8'h10, "R9 write landed");

        wr(8'hFF, 8'h07, "R10 select ch3");
        rd(8'h10, "R10 next access uses new page");
        step(1'b1, 1'b1, 8'hFF, 8'h04, "R10 same-edge page read returns old");
        rd(8'h10, "R10 later access uses ch0");

        for (int n = 0; n < 600; n++) begin
            logic [7:0] a;
            logic [7:0] d;
            int k;
            k = int'($urandom_range(0, 5));
            case (k)
                0: a = 8'h10;
                1: a = 8'h11;
                2: a = 8'h00;
                3: a = 8'hFE;
                default: a = 8'hFF;
            endcase
            d = 8'($urandom);
            step(bit'($urandom_range(0, 1)), bit'($urandom_range(0, 1)), a, d,
                 "R3 R4 R6 R7 random mix");
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule